// File: doc/BRIEF.md
# Z80 Bus Cycle Capture Unit

This block sits passively beside a Z80 processor and turns its bus activity into a stream of records, one for each completed memory or I/O bus cycle. A fast system clock samples all bus pins through synchronizers. The unit then captures each cycle in two stages. A holding register copies address, data and status whenever the synchronized CPU clock changes level. When a memory or I/O strobe ends, the held values become the output record.

The bus lines start changing on the CPU clock edge that closes a cycle, and they can change before the strobe has deasserted. Reading them directly on the strobe's trailing edge is therefore unsafe. With the two-stage scheme, the trailing edge only commits values that were already parked on an earlier CPU clock edge. Fetch and interrupt-acknowledge cycles end just after a rising CPU clock edge, and read and write cycles end just after a falling edge. For that reason the holding register follows both edges by default.

Records leave on a valid/ready stream. Refresh cycles can optionally be discarded. A commit that finds the output slot occupied is lost and raises a sticky overflow flag.

Top module: `z80_bus_tap`

## Requirements
- R1: After reset, `rec_valid` and `ovf_flag` are both 0.
- R2: With `cfg_rise_only` = 0, the holding register loads on both rising and falling CPU clock edges. With `cfg_rise_only` = 1, it loads on rising edges only, so data that first appears between a rising edge and the following falling edge is not seen in that mode.
- R3: A record is committed when either `z_mreq_n` or `z_iorq_n` goes from 0 to 1. The record takes its contents from the holding register, so bus changes made after the last CPU clock edge and before the strobe ends do not appear in it.
- R4: A record carries the 16-bit address, the 8-bit data and a 4-bit status. Status bit 3 is /WR, bit 2 is /IORQ, bit 1 is /RFSH and bit 0 is /M1, each at its raw active-low level as held.
- R5: With `cfg_drop_refresh` = 1, a commit that sees `z_rfsh_n` = 0 produces no record. With `cfg_drop_refresh` = 0, the refresh cycle is recorded with status bit 1 = 0.
- R6: While `rec_valid` = 1 and `rec_ready` = 0, the record and `rec_valid` stay unchanged. A cycle with `rec_ready` = 1 consumes the record.
- R7: A commit that arrives while a record is pending and not being accepted is dropped. The pending record is kept and `ovf_flag` becomes 1 and stays 1.
- R8: A one-cycle pulse on `ovf_clear` returns `ovf_flag` to 0. A new overflow in the same cycle keeps the flag at 1.
- R9: A commit that falls in the same system cycle as the acceptance of the pending record loads the new record and does not raise `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the CPU clock |
| rst_n | input | 1 | Active-low reset |
| cfg_rise_only | input | 1 | 1: holding register follows rising CPU clock edges only |
| cfg_drop_refresh | input | 1 | 1: discard commits during refresh |
| ovf_clear | input | 1 | Pulse to clear the overflow flag |
| z_clk | input | 1 | Z80 CPU clock |
| z_mreq_n | input | 1 | Memory request strobe, active low |
| z_iorq_n | input | 1 | I/O request strobe, active low |
| z_rfsh_n | input | 1 | Refresh indicator, active low |
| z_m1_n | input | 1 | Machine cycle one indicator, active low |
| z_wr_n | input | 1 | Write strobe, active low |
| z_addr | input | 16 | Address bus |
| z_data | input | 8 | Data bus |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_valid | output | 1 | A record is available |
| rec_addr | output | 16 | Record address |
| rec_data | output | 8 | Record data |
| rec_status | output | 4 | Record status {/WR, /IORQ, /RFSH, /M1} |
| ovf_flag | output | 1 | Sticky: a record was lost |

## Verification
A strobe's end can reach the commit logic in the same system cycle as the consumer's acceptance of the previous record. If the two are judged in the wrong order, a good record is flagged as lost. The bench provokes this case by leaving one record pending and then raising `rec_ready` for the single system cycle in which the synchronized trailing edge of the next strobe is detected. It then requires the second cycle's address at the output and `ovf_flag` still at 0. A companion case without acceptance requires the first record to be kept and the flag to be raised.

// File: rtl/z80tap_pkg.sv
package z80tap_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int STAT_W = 4;

    // synchronized view of the CPU bus; order fixes the synchronizer packing
    typedef struct packed {
        logic              cpu_clk;
        logic              mreq_n;
        logic              iorq_n;
        logic              rfsh_n;
        logic              m1_n;
        logic              wr_n;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } zbus_t;

    localparam int BUS_W = $bits(zbus_t);

    // status: [3]=/WR [2]=/IORQ [1]=/RFSH [0]=/M1
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [STAT_W-1:0] status;
    } tap_rec_t;
endpackage

// File: rtl/z80tap_sync.sv
module z80tap_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef logic [STAGES-1:0][W-1:0] chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/z80tap_hold.sv
module z80tap_hold
    import z80tap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_only,
    input  logic              cpu_clk_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic [STAT_W-1:0] status_s,
    output tap_rec_t          held
);
    typedef struct packed {
        logic     clk_prev;
        tap_rec_t hold;
    } hold_state_t;

    hold_state_t st_d, st_q;
    logic        rise_edge, fall_edge, take;

    always_comb begin
        st_d          = st_q;
        rise_edge     = cpu_clk_s & ~st_q.clk_prev;
        fall_edge     = ~cpu_clk_s & st_q.clk_prev;
        take          = rise_edge | (fall_edge & ~rise_only);
        st_d.clk_prev = cpu_clk_s;
        if (take) begin
            st_d.hold.addr   = addr_s;
            st_d.hold.data   = data_s;
            st_d.hold.status = status_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held = st_q.hold;

    // R2: in rising-only mode a low CPU clock never updates the holding register
    assert_rise_only_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_only && !cpu_clk_s) |=> $stable(held));

    // R2: a rising CPU clock edge always parks the bus
    assert_rise_parks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_s && !$past(cpu_clk_s)) |=> (held.addr == $past(addr_s)));
endmodule

// File: rtl/z80tap_commit.sv
module z80tap_commit
    import z80tap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     drop_refresh,
    input  logic     mreq_s,
    input  logic     iorq_s,
    input  logic     rfsh_s,
    input  tap_rec_t held,
    input  logic     rec_ready,
    input  logic     ovf_clear,
    output logic     rec_valid,
    output tap_rec_t rec,
    output logic     ovf
);
    typedef struct packed {
        logic     mreq_prev;
        logic     iorq_prev;
        logic     valid;
        tap_rec_t rec;
        logic     ovf;
    } commit_state_t;

    commit_state_t st_d, st_q;
    logic          strobe_end, keep, slot_free;

    always_comb begin
        st_d           = st_q;
        st_d.mreq_prev = mreq_s;
        st_d.iorq_prev = iorq_s;
        strobe_end     = (mreq_s & ~st_q.mreq_prev) | (iorq_s & ~st_q.iorq_prev);
        keep           = strobe_end & ~(drop_refresh & ~rfsh_s);
        slot_free      = ~st_q.valid | rec_ready;

        if (st_q.valid && rec_ready) st_d.valid = 1'b0;
        if (ovf_clear)               st_d.ovf   = 1'b0;

        if (keep) begin
            if (slot_free) begin
                st_d.valid = 1'b1;
                st_d.rec   = held;
            end else begin
                st_d.ovf   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.mreq_prev <= 1'b1;
            st_q.iorq_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rec_valid = st_q.valid;
    assign rec       = st_q.rec;
    assign ovf       = st_q.ovf;

    // R3: a new record only ever follows a strobe trailing edge
    assert_commit_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_valid) |-> $past(strobe_end));

    // R5: a refresh commit with filtering on leaves the output empty
    assert_refresh_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_end && drop_refresh && !rfsh_s && !rec_valid) |=> !rec_valid);

    // R6: a pending record is frozen until accepted
    assert_hold_record_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec)));

    // R7: a commit into an occupied slot raises the flag
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (keep && rec_valid && !rec_ready) |=> ovf);

    // R8: the flag only falls through a clear pulse
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clear) |=> ovf);

    // R9: commit meeting acceptance is taken without overflow
    assert_accept_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (keep && rec_valid && rec_ready && !ovf && !ovf_clear) |=> (rec_valid && !ovf));
endmodule

// File: rtl/z80_bus_tap.sv
module z80_bus_tap
    import z80tap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_rise_only,
    input  logic              cfg_drop_refresh,
    input  logic              ovf_clear,
    input  logic              z_clk,
    input  logic              z_mreq_n,
    input  logic              z_iorq_n,
    input  logic              z_rfsh_n,
    input  logic              z_m1_n,
    input  logic              z_wr_n,
    input  logic [ADDR_W-1:0] z_addr,
    input  logic [DATA_W-1:0] z_data,
    input  logic              rec_ready,
    output logic              rec_valid,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [DATA_W-1:0] rec_data,
    output logic [STAT_W-1:0] rec_status,
    output logic              ovf_flag
);
    zbus_t             bus_raw, bus_s;
    logic [BUS_W-1:0]  bus_sync;
    logic [STAT_W-1:0] status_s;
    tap_rec_t          held, rec;

    always_comb begin
        bus_raw.cpu_clk = z_clk;
        bus_raw.mreq_n  = z_mreq_n;
        bus_raw.iorq_n  = z_iorq_n;
        bus_raw.rfsh_n  = z_rfsh_n;
        bus_raw.m1_n    = z_m1_n;
        bus_raw.wr_n    = z_wr_n;
        bus_raw.addr    = z_addr;
        bus_raw.data    = z_data;
    end

    z80tap_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (bus_raw),
        .dout (bus_sync)
    );

    assign bus_s    = zbus_t'(bus_sync);
    assign status_s = {bus_s.wr_n, bus_s.iorq_n, bus_s.rfsh_n, bus_s.m1_n};

    z80tap_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_only(cfg_rise_only),
        .cpu_clk_s(bus_s.cpu_clk),
        .addr_s   (bus_s.addr),
        .data_s   (bus_s.data),
        .status_s (status_s),
        .held     (held)
    );

    z80tap_commit u_commit (
        .clk         (clk),
        .rst_n       (rst_n),
        .drop_refresh(cfg_drop_refresh),
        .mreq_s      (bus_s.mreq_n),
        .iorq_s      (bus_s.iorq_n),
        .rfsh_s      (bus_s.rfsh_n),
        .held        (held),
        .rec_ready   (rec_ready),
        .ovf_clear   (ovf_clear),
        .rec_valid   (rec_valid),
        .rec         (rec),
        .ovf         (ovf_flag)
    );

    assign rec_addr   = rec.addr;
    assign rec_data   = rec.data;
    assign rec_status = rec.status;

    // R1: nothing is offered in the cycle right after reset release
    assert_reset_idle_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!rec_valid && !ovf_flag));
endmodule

// File: tb/sim_z80_bus_tap.sv
module sim_z80_bus_tap;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rise_only = 1'b0, cfg_drop_refresh = 1'b0, ovf_clear = 1'b0;
    logic        z_clk = 1'b0, z_mreq_n = 1'b1, z_iorq_n = 1'b1;
    logic        z_rfsh_n = 1'b1, z_m1_n = 1'b1, z_wr_n = 1'b1;
    logic [15:0] z_addr = '0;
    logic [7:0]  z_data = '0;
    logic        rec_ready = 1'b0;
    logic        rec_valid, ovf_flag;
    logic [15:0] rec_addr;
    logic [7:0]  rec_data;
    logic [3:0]  rec_status;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    z80_bus_tap u0 (
        .clk(clk), .rst_n(rst_n), .cfg_rise_only(cfg_rise_only),
        .cfg_drop_refresh(cfg_drop_refresh), .ovf_clear(ovf_clear),
        .z_clk(z_clk), .z_mreq_n(z_mreq_n), .z_iorq_n(z_iorq_n),
        .z_rfsh_n(z_rfsh_n), .z_m1_n(z_m1_n), .z_wr_n(z_wr_n),
        .z_addr(z_addr), .z_data(z_data), .rec_ready(rec_ready),
        .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_data(rec_data),
        .rec_status(rec_status), .ovf_flag(ovf_flag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic half();
        repeat (4) @(negedge clk);
        z_clk = ~z_clk;
    endtask

    // one bus cycle; the address and data are corrupted after the last CPU edge
    task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d, input bit io,
                             input bit wr_n, input bit m1_n, input bit rfsh_n,
                             input bit end_rise, input bit late, input bit accept_mid);
        @(negedge clk);
        z_addr = a; z_data = late ? ~d : d;
        z_wr_n = wr_n; z_m1_n = m1_n; z_rfsh_n = rfsh_n;
        half(); half();
        if (io) z_iorq_n = 1'b0; else z_mreq_n = 1'b0;
        half();
        if (end_rise) begin
            half(); half();
        end else if (late) begin
            @(negedge clk); z_data = d;
            repeat (3) @(negedge clk); z_clk = ~z_clk;
        end else begin
            half();
        end
        repeat (2) @(negedge clk);
        z_addr = ~a; z_data = ~d;
        @(negedge clk);
        z_mreq_n = 1'b1; z_iorq_n = 1'b1;
        repeat (2) @(negedge clk);
        if (accept_mid) rec_ready = 1'b1;
        @(negedge clk);
        rec_ready = 1'b0;
        z_wr_n = 1'b1; z_m1_n = 1'b1; z_rfsh_n = 1'b1;
        if (z_clk) half();
        repeat (8) @(negedge clk);
    endtask

    task automatic consume();
        @(negedge clk); rec_ready = 1'b1;
        @(negedge clk); rec_ready = 1'b0;
    endtask

    task automatic check_rec(input string req, input logic [15:0] a,
                             input logic [7:0] d, input logic [3:0] s);
        check(rec_valid == 1'b1, req, "valid", int'(rec_valid), 1);
        check(rec_addr == a, req, "addr", int'(rec_addr), int'(a));
        check(rec_data == d, req, "data", int'(rec_data), int'(d));
        check(rec_status == s, req, "status", int'(rec_status), int'(s));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        logic [7:0]  d, de;
        logic [3:0]  s;
        bit io, wr, m1, er, late;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check(rec_valid == 1'b0, "R1", "valid", int'(rec_valid), 0);
        check(ovf_flag == 1'b0, "R1", "ovf", int'(ovf_flag), 0);

        // R2 R3 R4: sweep of cycle kinds in both edge modes
        for (int mode = 0; mode < 2; mode++) begin
            cfg_rise_only = mode[0]; cfg_drop_refresh = mode[0];
            for (int kind = 0; kind < 6; kind++) begin
                for (int k = 0; k < 3; k++) begin
                    a = 16'(kind * 16'h1357 + k * 16'h2468 + mode * 16'h0F0F);
                    d = a[7:0] ^ a[15:8] ^ 8'(k);
                    io   = (kind >= 3);
                    wr   = !(kind == 2 || kind == 4);
                    m1   = !(kind == 0 || kind == 5);
                    er   = (kind == 0 || kind == 5);
                    late = (kind == 1 || kind == 3);
                    bus_cycle(a, d, io, wr, m1, 1'b1, er, late, 1'b0);
                    de = (late && mode == 1) ? ~d : d;
                    s  = {wr, !io, 1'b1, m1};
                    check_rec(mode == 1 ? "R2_rise_only" : "R2_R3_R4_both_edges", a, de, s);
                    consume();
                    check(rec_valid == 1'b0, "R6", "valid after accept", int'(rec_valid), 0);
                end
            end
        end

        // R5: refresh filtered, then recorded
        cfg_rise_only = 1'b0; cfg_drop_refresh = 1'b1;
        bus_cycle(16'h007F, 8'h3C, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        check(rec_valid == 1'b0, "R5", "refresh dropped", int'(rec_valid), 0);
        cfg_drop_refresh = 1'b0;
        bus_cycle(16'h0041, 8'h5A, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        check_rec("R5", 16'h0041, 8'h5A, 4'b1101);
        consume();

        // R6 R7: second commit into an occupied slot
        bus_cycle(16'hA001, 8'h11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        bus_cycle(16'hB002, 8'h22, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check_rec("R6_R7", 16'hA001, 8'h11, 4'b1111);
        check(ovf_flag == 1'b1, "R7", "ovf", int'(ovf_flag), 1);
        repeat (20) @(negedge clk);
        check(ovf_flag == 1'b1, "R7", "ovf sticky", int'(ovf_flag), 1);

        // R8: clear pulse
        ovf_clear = 1'b1; @(negedge clk); ovf_clear = 1'b0;
        @(negedge clk);
        check(ovf_flag == 1'b0, "R8", "ovf after clear", int'(ovf_flag), 0);
        check_rec("R8", 16'hA001, 8'h11, 4'b1111);
        consume();

        // R9: commit lands on the acceptance cycle
        bus_cycle(16'hC003, 8'h33, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        bus_cycle(16'hD004, 8'h44, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        check_rec("R9", 16'hD004, 8'h44, 4'b0011);
        check(ovf_flag == 1'b0, "R9", "ovf", int'(ovf_flag), 0);
        consume();

        done = 1;
        summary();
        $finish;
    end
endmodule